// File: doc/BRIEF.md
# Single-wire slave ROM command controller

This block is the network-layer controller of a slave on a single-wire open-drain bus. A bit-level line interface underneath it handles the line, the slot timing and reset detection. It passes this controller one event per bus reset, one pulse per bit the master writes, and one acknowledge per bit the slave has sent. The controller holds the slave's fixed 64-bit identity. Identity bit 0 is the least-significant bit of an 8-bit family code. It is followed by a 48-bit serial number and an 8-bit check byte, which is computed at elaboration. After each reset the controller asks for a presence pulse, reads one command byte, and then reads out, compares or runs the bitwise arbitration against that identity.

When addressing succeeds, the controller raises a one-cycle grant to the memory-function layer above. It then stays silent until the next reset. When addressing fails, or the command byte is not known, it goes idle until the next reset. Two flags persist across resets:
- a resume flag, which lets a slave that was addressed earlier be selected again with a single command;
- an overdrive flag, which tells the line interface to use fast timing. Only a reset that the line interface marks as short keeps it set.

Top module: `onewire_rom_ctrl`

## Requirements
- R1: In the cycle after `resetSeen`, `presence` is high for exactly one cycle. The controller then raises `rxReq` and takes 8 command bits, least-significant bit first. A `rxValid` pulse counts only while `rxReq` is high.
- R2: Command 33h (read identity) clears the resume flag. It then sends all 64 identity bits in order, index 0 first, one per `txDone`, and raises `grant`. The family code supplies bits 0 to 7 and the serial number bits 8 to 55. Bits 56 to 63 are the check byte: an 8-bit CRC with polynomial x^8+x^5+x^4+1, initial value 0, shifted in least-significant bit first over the 56 bits of family code and serial number.
- R3: Command 55h (match) clears the resume flag and compares 64 master bits with the identity, index 0 first. If all 64 match, it sets the resume flag and pulses `grant`. On the first mismatch, `rxReq`, `txReq` and `grant` stay low until the next reset.
- R4: Command F0h (search) clears the resume flag. For each identity bit in turn it sends the bit, then the bit's complement, then reads one master bit. A master bit that differs ends the search silently until reset. When all 64 bits agree, it sets the resume flag and pulses `grant`.
- R5: Command CCh (skip) clears the resume flag and pulses `grant` without any identity traffic.
- R6: Command 3Ch (fast skip) clears the resume flag, sets `overdrive` and pulses `grant`.
- R7: Command 69h (fast match) clears the resume flag, sets `overdrive` before the first compare bit, and then behaves like the match command. On a mismatch, `overdrive` returns to the value it had before the command.
- R8: Command A5h (resume) pulses `grant` when the resume flag is set. When the flag is clear, the controller goes idle without a grant. The resume flag is set only by a successful match or search.
- R9: A reset with `resetShort` low clears `overdrive`. A reset with `resetShort` high leaves `overdrive` unchanged.
- R10: After system reset, and after any command byte not listed above, `rxReq`, `txReq` and `grant` stay low until the next bus reset. In this state `rxValid` pulses have no effect.
- R11: While `txReq` is high and `txDone` is low, `txReq` stays high and `txBit` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resetSeen | input | 1 | One-cycle pulse: the line interface detected a bus reset |
| resetShort | input | 1 | Qualifies `resetSeen`: the reset was of fast-speed length |
| rxValid | input | 1 | One-cycle pulse: a master-written bit is on `rxBit` |
| rxBit | input | 1 | Value of the master-written bit |
| txDone | input | 1 | One-cycle pulse: the line interface finished sending `txBit` |
| presence | output | 1 | One-cycle request to send a presence pulse |
| rxReq | output | 1 | Controller expects a master-written bit |
| txReq | output | 1 | Controller has a bit to send in the next read slot |
| txBit | output | 1 | Bit to send while `txReq` is high |
| grant | output | 1 | One-cycle hand-off to the memory-function layer |
| overdrive | output | 1 | Fast-speed flag for the line interface |

## Verification
The assertions check these properties on every cycle:
- a presence request follows each bus reset;
- a reset that is not short always drops the fast-speed flag, and a short one keeps it;
- a pending transmit bit stays steady until it is acknowledged;
- a compare mismatch silences the bus side at once;
- the grant is a single-cycle pulse;
- the bit index never runs past the last identity bit.

Only the bench scenarios can show the rest. That covers:
- the exact 64-bit order and check byte of the identity;
- the true-then-complement order of the search;
- the life of the resume flag across commands and resets;
- restoring the fast-speed flag after a failed fast match, which depends on the flag's value before the command;
- the silence after an unknown command byte.

// File: rtl/onewire_rom_pkg.sv
package onewire_rom_pkg;

  localparam int FAM_W    = 8;
  localparam int SER_W    = 48;
  localparam int CHK_W    = 8;
  localparam int CMD_BITS = 8;
  localparam int ID_BITS  = FAM_W + SER_W + CHK_W;
  localparam int IDX_W    = $clog2(ID_BITS);

  localparam logic [7:0] CMD_SEARCH  = 8'hF0;
  localparam logic [7:0] CMD_MATCH   = 8'h55;
  localparam logic [7:0] CMD_READ    = 8'h33;
  localparam logic [7:0] CMD_SKIP    = 8'hCC;
  localparam logic [7:0] CMD_FMATCH  = 8'h69;
  localparam logic [7:0] CMD_FSKIP   = 8'h3C;
  localparam logic [7:0] CMD_RESUME  = 8'hA5;

  typedef enum logic [3:0] {
    ST_WAIT, ST_PRES, ST_CMD, ST_DISP, ST_READ,
    ST_STRUE, ST_SCMPL, ST_SRX, ST_MATCH, ST_GRANT, ST_MEM
  } romState_t;

  typedef struct packed {
    logic clrIdx;
    logic incIdx;
    logic shiftCmd;
  } idStrobe_t;

  // Check byte: polynomial x^8+x^5+x^4+1, shifted LSB first, seed zero.
  function automatic logic [CHK_W-1:0] checkByte(input logic [FAM_W+SER_W-1:0] body);
    logic [CHK_W-1:0] acc;
    logic             mix;
    acc = '0;
    for (int i = 0; i < FAM_W + SER_W; i++) begin
      mix = acc[0] ^ body[i];
      acc = acc >> 1;
      if (mix) acc = acc ^ 8'h8C;
    end
    return acc;
  endfunction

endpackage

// File: rtl/onewire_rom_idpath.sv
module onewire_rom_idpath
  import onewire_rom_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h43,
  parameter logic [SER_W-1:0] SERIAL_NUM  = 48'h0000_5A3C_1E97
) (
  input  logic          clk,
  input  logic          rstN,
  input  idStrobe_t     strb,
  input  logic          rxBit,
  output logic          idBit,
  output logic          idxLast,
  output logic          cmdLast,
  output logic [7:0]    cmdByte
);

  localparam logic [FAM_W+SER_W-1:0] BODY = {SERIAL_NUM, FAMILY_CODE};
  localparam logic [ID_BITS-1:0] ROM_ID = {checkByte(BODY), BODY};

  logic [IDX_W-1:0] idx;
  logic [7:0]       cmdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx    <= '0;
      cmdReg <= '0;
    end else begin
      if (strb.clrIdx)      idx <= '0;
      else if (strb.incIdx) idx <= idx + 1'b1;
      if (strb.shiftCmd)    cmdReg <= {rxBit, cmdReg[7:1]};
    end
  end

  assign idBit   = ROM_ID[idx];
  assign idxLast = (idx == IDX_W'(ID_BITS - 1));
  assign cmdLast = (idx == IDX_W'(CMD_BITS - 1));
  assign cmdByte = cmdReg;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.incIdx && !strb.clrIdx |=> idx != '0);  // R2

endmodule

// File: rtl/onewire_rom_fsm.sv
module onewire_rom_fsm
  import onewire_rom_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       resetSeen,
  input  logic       resetShort,
  input  logic       rxValid,
  input  logic       rxBit,
  input  logic       txDone,
  input  logic       idBit,
  input  logic       idxLast,
  input  logic       cmdLast,
  input  logic [7:0] cmdByte,
  output idStrobe_t  strb,
  output logic       presence,
  output logic       rxReq,
  output logic       txReq,
  output logic       txBit,
  output logic       grant,
  output logic       overdrive
);

  romState_t state;
  logic      rcFlag;
  logic      odFlag;
  logic      odBefore;
  logic      bitAgree;

  assign bitAgree = (rxBit == idBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_WAIT;
      rcFlag   <= 1'b0;
      odFlag   <= 1'b0;
      odBefore <= 1'b0;
    end else if (resetSeen) begin
      state  <= ST_PRES;
      odFlag <= odFlag & resetShort;
    end else begin
      case (state)
        ST_PRES: state <= ST_CMD;
        ST_CMD:  if (rxValid && cmdLast) state <= ST_DISP;
        ST_DISP: begin
          odBefore <= odFlag;
          case (cmdByte)
            CMD_SEARCH: begin rcFlag <= 1'b0; state <= ST_STRUE; end
            CMD_MATCH:  begin rcFlag <= 1'b0; state <= ST_MATCH; end
            CMD_READ:   begin rcFlag <= 1'b0; state <= ST_READ;  end
            CMD_SKIP:   begin rcFlag <= 1'b0; state <= ST_GRANT; end
            CMD_FSKIP:  begin rcFlag <= 1'b0; odFlag <= 1'b1; state <= ST_GRANT; end
            CMD_FMATCH: begin rcFlag <= 1'b0; odFlag <= 1'b1; state <= ST_MATCH; end
            CMD_RESUME: state <= rcFlag ? ST_GRANT : ST_WAIT;
            default:    state <= ST_WAIT;
          endcase
        end
        ST_READ:  if (txDone && idxLast) state <= ST_GRANT;
        ST_STRUE: if (txDone) state <= ST_SCMPL;
        ST_SCMPL: if (txDone) state <= ST_SRX;
        ST_SRX: if (rxValid) begin
          if (!bitAgree)    state <= ST_WAIT;
          else if (idxLast) begin rcFlag <= 1'b1; state <= ST_GRANT; end
          else              state <= ST_STRUE;
        end
        ST_MATCH: if (rxValid) begin
          if (!bitAgree)    begin odFlag <= odBefore; state <= ST_WAIT; end
          else if (idxLast) begin rcFlag <= 1'b1; state <= ST_GRANT; end
        end
        ST_GRANT: state <= ST_MEM;
        default:  state <= state;
      endcase
    end
  end

  always_comb begin
    strb.shiftCmd = (state == ST_CMD) && rxValid;
    strb.clrIdx   = (state == ST_PRES) || (state == ST_DISP);
    strb.incIdx   = ((state == ST_CMD) && rxValid && !cmdLast)
                 || ((state == ST_READ) && txDone && !idxLast)
                 || ((state == ST_SRX) && rxValid && bitAgree && !idxLast)
                 || ((state == ST_MATCH) && rxValid && bitAgree && !idxLast);
  end

  assign presence  = (state == ST_PRES);
  assign rxReq     = (state == ST_CMD) || (state == ST_SRX) || (state == ST_MATCH);
  assign txReq     = (state == ST_READ) || (state == ST_STRUE) || (state == ST_SCMPL);
  assign txBit     = (state == ST_SCMPL) ? ~idBit : idBit;
  assign grant     = (state == ST_GRANT);
  assign overdrive = odFlag;

  AST_PRESENCE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    resetSeen |=> presence);  // R1
  AST_OD_LONG_RESET: assert property (@(posedge clk) disable iff (!rstN)
    resetSeen && !resetShort |=> !overdrive);  // R9
  AST_OD_SHORT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    resetSeen && resetShort |=> $stable(overdrive));  // R9
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    txReq && !txDone && !resetSeen |=> txReq && $stable(txBit));  // R11
  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MATCH) && rxValid && !bitAgree && !resetSeen
      |=> !rxReq && !txReq && !grant);  // R3
  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    grant && !resetSeen |=> !grant);  // R5

endmodule

// File: rtl/onewire_rom_ctrl.sv
module onewire_rom_ctrl
  import onewire_rom_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h43,
  parameter logic [SER_W-1:0] SERIAL_NUM  = 48'h0000_5A3C_1E97
) (
  input  logic clk,
  input  logic rstN,
  input  logic resetSeen,
  input  logic resetShort,
  input  logic rxValid,
  input  logic rxBit,
  input  logic txDone,
  output logic presence,
  output logic rxReq,
  output logic txReq,
  output logic txBit,
  output logic grant,
  output logic overdrive
);

  idStrobe_t  strb;
  logic       idBit;
  logic       idxLast;
  logic       cmdLast;
  logic [7:0] cmdByte;

  onewire_rom_idpath #(
    .FAMILY_CODE(FAMILY_CODE),
    .SERIAL_NUM (SERIAL_NUM)
  ) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rxBit  (rxBit),
    .idBit  (idBit),
    .idxLast(idxLast),
    .cmdLast(cmdLast),
    .cmdByte(cmdByte)
  );

  onewire_rom_fsm uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .resetSeen (resetSeen),
    .resetShort(resetShort),
    .rxValid   (rxValid),
    .rxBit     (rxBit),
    .txDone    (txDone),
    .idBit     (idBit),
    .idxLast   (idxLast),
    .cmdLast   (cmdLast),
    .cmdByte   (cmdByte),
    .strb      (strb),
    .presence  (presence),
    .rxReq     (rxReq),
    .txReq     (txReq),
    .txBit     (txBit),
    .grant     (grant),
    .overdrive (overdrive)
  );

endmodule

// File: tb/tb_onewire_rom_ctrl.sv
module tb_onewire_rom_ctrl;

  localparam logic [7:0]  FAM = 8'h43;
  localparam logic [47:0] SER = 48'h0000_5A3C_1E97;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic resetSeen = 1'b0, resetShort = 1'b0;
  logic rxValid = 1'b0, rxBit = 1'b0, txDone = 1'b0;
  logic presence, rxReq, txReq, txBit, grant, overdrive;

  int checks = 0;
  int failures = 0;
  int grantCnt = 0;
  bit finished = 1'b0;
  logic [63:0] expId;

  always #2 clk = ~clk;

  onewire_rom_ctrl #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) dut (
    .clk(clk), .rstN(rstN), .resetSeen(resetSeen), .resetShort(resetShort),
    .rxValid(rxValid), .rxBit(rxBit), .txDone(txDone),
    .presence(presence), .rxReq(rxReq), .txReq(txReq), .txBit(txBit),
    .grant(grant), .overdrive(overdrive));

  always @(posedge clk) if (rstN && grant) grantCnt++;

  function automatic logic [7:0] refCrc(input logic [55:0] d);
    logic [7:0] c;
    logic fb;
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      fb = c[0] ^ d[i];
      c = {fb, c[7:1]} ^ {4'b0000, fb, fb, 2'b00};
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busReset(input bit shortRst);
    @(negedge clk);
    resetSeen = 1'b1; resetShort = shortRst;
    @(negedge clk);
    resetSeen = 1'b0; resetShort = 1'b0;
    check(presence === 1'b1, "R1 presence after reset", presence, 1);
  endtask

  task automatic sendBit(input bit b);
    int n = 0;
    while (rxReq !== 1'b1 && n < 60) begin @(negedge clk); n++; end
    if (rxReq !== 1'b1) check(0, "R1 rxReq timeout", 0, 1);
    rxValid = 1'b1; rxBit = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic getBit(output bit b);
    int n = 0;
    while (txReq !== 1'b1 && n < 60) begin @(negedge clk); n++; end
    if (txReq !== 1'b1) check(0, "R11 txReq timeout", 0, 1);
    b = txBit;
    txDone = 1'b1;
    @(negedge clk);
    txDone = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendBit(v[i]);
  endtask

  task automatic expectGrant(input int g0, input bit want, input string tag);
    repeat (4) @(negedge clk);
    check(grantCnt == g0 + (want ? 1 : 0), tag, grantCnt - g0, want ? 1 : 0);
    check(rxReq === 1'b0 && txReq === 1'b0, {tag, " quiet after"}, {rxReq, txReq}, 0);
  endtask

  // flipPos = 64 means send the identity unchanged
  task automatic matchRun(input logic [7:0] cmd, input int flipPos, input string tag);
    int g0 = grantCnt;
    sendByte(cmd);
    for (int i = 0; i < 64 && i <= flipPos; i++) sendBit(expId[i] ^ (i == flipPos));
    expectGrant(g0, flipPos == 64, tag);
  endtask

  task automatic searchRun(input int flipPos, input string tag);
    int g0 = grantCnt;
    bit t, c;
    int bad = 0;
    sendByte(8'hF0);
    for (int i = 0; i < 64 && i <= flipPos; i++) begin
      getBit(t);
      getBit(c);
      if (t !== expId[i] || c !== ~expId[i]) bad++;
      sendBit(expId[i] ^ (i == flipPos));
    end
    check(bad == 0, {tag, " true/complement pairs"}, bad, 0);
    expectGrant(g0, flipPos == 64, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int g0;
    int bad;
    bit b, b0;
    expId = {refCrc({SER, FAM}), SER, FAM};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rxReq === 0 && txReq === 0 && grant === 0 && overdrive === 0,
          "R10 reset state", {rxReq, txReq, grant, overdrive}, 0);
    rxValid = 1'b1; @(negedge clk); rxValid = 1'b0;
    repeat (2) @(negedge clk);
    check(rxReq === 0 && txReq === 0, "R10 rxValid ignored when idle", {rxReq, txReq}, 0);

    // R2 read, with R11 hold check on the first bit
    busReset(1'b0);
    g0 = grantCnt;
    sendByte(8'h33);
    while (txReq !== 1'b1) @(negedge clk);
    b0 = txBit;
    repeat (3) @(negedge clk);
    check(txReq === 1'b1 && txBit === b0, "R11 tx held until done", {txReq, txBit}, {1'b1, b0});
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      getBit(b);
      if (b !== expId[i]) begin
        bad++;
        check(0, "R2 read bit", i, expId[i]);
      end
    end
    check(bad == 0, "R2 read identity", bad, 0);
    expectGrant(g0, 1, "R2 grant after read");
    busReset(1'b0); g0 = grantCnt; sendByte(8'hA5);
    expectGrant(g0, 0, "R8 resume after read refused");

    // R3 match and R8 resume
    busReset(1'b0); matchRun(8'h55, 64, "R3 full match");
    check(overdrive === 0, "R3 match keeps od", overdrive, 0);
    busReset(1'b0); g0 = grantCnt; sendByte(8'hA5);
    expectGrant(g0, 1, "R8 resume after match");
    busReset(1'b0); g0 = grantCnt; sendByte(8'hA5);
    expectGrant(g0, 1, "R8 resume repeated");
    busReset(1'b0); g0 = grantCnt; sendByte(8'hCC);
    expectGrant(g0, 1, "R5 skip grant");
    busReset(1'b0); g0 = grantCnt; sendByte(8'hA5);
    expectGrant(g0, 0, "R8 resume after skip refused");

    foreach (expId[k]) begin
      if (k == 0 || k == 1 || k == 7 || k == 8 || k == 31 || k == 55 || k == 56 || k == 63) begin
        busReset(1'b0); matchRun(8'h55, k, "R3 mismatch drop");
      end
    end

    // R4 search
    busReset(1'b0); searchRun(64, "R4 full search");
    busReset(1'b0); g0 = grantCnt; sendByte(8'hA5);
    expectGrant(g0, 1, "R4 R8 resume after search");
    busReset(1'b0); searchRun(0, "R4 search drop at bit 0");
    busReset(1'b0); searchRun(20, "R4 search drop at bit 20");
    busReset(1'b0); searchRun(63, "R4 search drop at bit 63");
    busReset(1'b0); g0 = grantCnt; sendByte(8'hA5);
    expectGrant(g0, 0, "R8 resume after failed search");

    // R6 / R9 overdrive
    busReset(1'b0); g0 = grantCnt; sendByte(8'h3C);
    expectGrant(g0, 1, "R6 fast skip grant");
    check(overdrive === 1, "R6 od set", overdrive, 1);
    busReset(1'b1);
    check(overdrive === 1, "R9 short reset keeps od", overdrive, 1);
    busReset(1'b0);
    check(overdrive === 0, "R9 long reset clears od", overdrive, 0);
    busReset(1'b1);
    check(overdrive === 0, "R9 short reset with od clear", overdrive, 0);

    // R7 fast match
    busReset(1'b0); sendByte(8'h69);
    while (rxReq !== 1'b1) @(negedge clk);
    check(overdrive === 1, "R7 od set before compare", overdrive, 1);
    for (int i = 0; i < 5; i++) sendBit(expId[i]);
    sendBit(~expId[5]);
    repeat (2) @(negedge clk);
    check(overdrive === 0, "R7 od restored to 0", overdrive, 0);
    busReset(1'b0); sendByte(8'h3C);
    busReset(1'b1); matchRun(8'h69, 9, "R7 mismatch from fast");
    check(overdrive === 1, "R7 od kept at 1", overdrive, 1);
    busReset(1'b0); matchRun(8'h69, 64, "R7 full fast match");
    check(overdrive === 1, "R7 od after full match", overdrive, 1);
    busReset(1'b1); g0 = grantCnt; sendByte(8'hA5);
    expectGrant(g0, 1, "R8 resume after fast match");

    // R10 unknown commands
    busReset(1'b0); g0 = grantCnt; sendByte(8'h00);
    expectGrant(g0, 0, "R10 unknown 00h");
    rxValid = 1'b1; rxBit = 1'b1; @(negedge clk); rxValid = 1'b0;
    repeat (2) @(negedge clk);
    check(rxReq === 0 && txReq === 0, "R10 ignored bit after unknown", {rxReq, txReq}, 0);
    busReset(1'b0); g0 = grantCnt; sendByte(8'hFF);
    expectGrant(g0, 0, "R10 unknown FFh");
    busReset(1'b0); g0 = grantCnt; sendByte(8'hCC);
    expectGrant(g0, 1, "R5 skip after unknown");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule